// File: doc/BRIEF.md
# Boot Image Serial Streamer

This block is the device end of a single-lane boot transfer. A command decoder upstream hands it one decoded command code with a one-cycle valid strobe. When a boot-initiation command arrives while the block is quiet, it starts shifting a fixed boot image out of an internal ROM onto a serial data line, one bit per host clock. The image is stored fully formatted, with the acknowledge pattern, start bits, CRC and end bits already in place. The block therefore only replays it bit for bit.

The host controls the pace only by running or stopping its clock, so no handshake exists. While a transfer is running, a go-idle or go-pre-idle command cuts it off at once. The host also sends go-idle after a transfer that finished normally. Whenever no image bit is being presented, the data line rests high. A boot-initiation received during a transfer is ignored, and the transfer keeps running from where it is.

The ROM contents come from parameters: byte i of the image is (SEED + i*STEP) mod 256. The image is IMG_BYTES bytes long.

Top module: `boot_stream_top`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `busy` is 0 and `dat_out` is 1.
- R2: With `busy` low, a valid command with code 2'b01 (go-idle), 2'b10 (go-pre-idle) or 2'b00 (error) has no effect: `busy` stays 0 and `dat_out` stays 1.
- R3: With `busy` low, a valid command with code 2'b11 (boot-initiation) sets `busy` at that rising edge. Image bit 0 appears on `dat_out` at the next falling edge.
- R4: Image bit k is byte k/8, bit 7-(k mod 8), so bytes go out in order, MSB first. One bit is sent per clock period. `dat_out` changes only on falling edges of `clk`.
- R5: Byte i of the image equals (SEED + i*STEP) mod 256, for i from 0 to IMG_BYTES-1.
- R6: With `busy` high, a boot-initiation or error command has no effect: the stream continues with the next bit and does not restart.
- R7: With `busy` high, a valid go-idle or go-pre-idle command clears `busy` at that rising edge, and `dat_out` is 1 from the next falling edge on.
- R8: After the last image bit, `dat_out` is held at 1 and `busy` stays 1 until a go-idle or go-pre-idle command arrives.
- R9: While the host clock is stopped, `dat_out` holds its current bit, and the stream resumes with the next bit when the clock restarts.
- R10: Whenever `busy` is 0, `dat_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; the data line changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_code` |
| cmd_code | input | 2 | 00 error, 01 go-idle, 10 go-pre-idle, 11 boot-initiation |
| dat_out | output | 1 | Serial boot data, high when idle |
| busy | output | 1 | Transmit state flag |

## Verification
A command is sampled at the rising edge that follows the falling edge where it was driven. `busy` responds at that same rising edge. `dat_out` responds at the falling edge half a period later, so the first image bit, and the high level after an abort, are both due one falling edge after the command is taken. The bench drives inputs and samples outputs one time unit after each falling edge. Each check of image bit k therefore falls k falling edges after the first bit. During a clock pause, the bench checks the held level after several periods without edges.

// File: rtl/boot_stream_pkg.sv
package boot_stream_pkg;

  typedef enum logic [1:0] {
    CMD_ERROR    = 2'b00,
    CMD_GO_IDLE  = 2'b01,
    CMD_PRE_IDLE = 2'b10,
    CMD_BOOT     = 2'b11
  } cmd_e;

  // Image byte generator shared by the ROM.
  function automatic logic [7:0] img_byte(input int unsigned idx,
                                          input logic [7:0] seed,
                                          input logic [7:0] step);
    logic [15:0] acc;
    acc = 16'(seed) + 16'(idx[7:0]) * 16'(step);
    return acc[7:0];
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/boot_img_rom.sv
module boot_img_rom
  import boot_stream_pkg::*;
#(
  parameter int          IMG_BYTES = 16,
  parameter logic [7:0]  SEED      = 8'hC3,
  parameter logic [7:0]  STEP      = 8'h35,
  parameter int          PTR_W     = 8
) (
  input  logic [PTR_W-1:0] bit_idx,
  output logic             bit_val
);
  localparam int BYTE_W    = PTR_W - 3;
  localparam int ROM_DEPTH = 2 ** BYTE_W;

  logic [7:0]        rom [ROM_DEPTH];
  logic [BYTE_W-1:0] byte_idx;
  logic [2:0]        bit_sel;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    if (g < IMG_BYTES) begin : g_img
      assign rom[g] = img_byte(g, SEED, STEP);
    end else begin : g_pad
      assign rom[g] = 8'hFF;
    end
  end

  assign byte_idx = bit_idx[PTR_W-1:3];
  assign bit_sel  = 3'd7 - bit_idx[2:0];
  assign bit_val  = rom[byte_idx][bit_sel];
endmodule

// File: rtl/boot_tx_ctrl.sv
module boot_tx_ctrl
  import boot_stream_pkg::*;
#(
  parameter int LEN_BITS = 128,
  parameter int PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  output logic             busy,
  output logic             done,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LEN_BITS);

  logic             busy_q, busy_d, busy_en;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             is_boot, is_idle_type, start, abort;

  always_comb begin
    is_boot      = cmd_valid && (cmd_code == CMD_BOOT);
    is_idle_type = cmd_valid && ((cmd_code == CMD_GO_IDLE) || (cmd_code == CMD_PRE_IDLE));
    start        = is_boot && !busy_q;
    abort        = is_idle_type && busy_q;
    busy_en      = start || abort;
    busy_d       = start;
    ptr_en       = start || (busy_q && !abort && (ptr_q != LAST));
    ptr_d        = start ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= LAST;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (ptr_en)  ptr_q  <= ptr_d;
    end
  end

  assign busy = busy_q;
  assign ptr  = ptr_q;
  assign done = (ptr_q == LAST);

  a_r2_ignore_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_code != CMD_BOOT) |=> !busy);

  a_r3_boot_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_code == CMD_BOOT) |=> (busy && ptr == '0));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmd_valid && (cmd_code == CMD_BOOT || cmd_code == CMD_ERROR))
      |=> (busy && ptr == $past(ptr) + 1'b1));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && (cmd_code == CMD_GO_IDLE || cmd_code == CMD_PRE_IDLE)) |=> !busy);

  a_r8_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !(cmd_valid && (cmd_code == CMD_GO_IDLE || cmd_code == CMD_PRE_IDLE)))
      |=> (busy && done));

  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/boot_dat_drive.sv
module boot_dat_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic done,
  input  logic rom_bit,
  output logic dat_out
);
  logic dat_q, dat_d;

  always_comb begin
    dat_d = (busy && !done) ? rom_bit : 1'b1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= 1'b1;
    else        dat_q <= dat_d;
  end

  assign dat_out = dat_q;
endmodule

// File: rtl/boot_stream_top.sv
module boot_stream_top
  import boot_stream_pkg::*;
#(
  parameter int         IMG_BYTES = 16,
  parameter logic [7:0] SEED      = 8'hC3,
  parameter logic [7:0] STEP      = 8'h35,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  output logic       dat_out,
  output logic       busy
);
  localparam int LEN_BITS = IMG_BYTES * 8;
  localparam int PTR_W    = $clog2(LEN_BITS + 1);

  logic             rst_sync_n;
  logic             done;
  logic [PTR_W-1:0] ptr;
  logic             rom_bit;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  boot_tx_ctrl #(.LEN_BITS(LEN_BITS), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .busy      (busy),
    .done      (done),
    .ptr       (ptr)
  );

  boot_img_rom #(.IMG_BYTES(IMG_BYTES), .SEED(SEED), .STEP(STEP), .PTR_W(PTR_W)) u_rom (
    .bit_idx (ptr),
    .bit_val (rom_bit)
  );

  boot_dat_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .busy    (busy),
    .done    (done),
    .rom_bit (rom_bit),
    .dat_out (dat_out)
  );

  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> dat_out);

  a_r8_done_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && done) |-> dat_out);
endmodule

// File: tb/boot_stream_top_tb_top.sv
module boot_stream_top_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         IMG_BYTES  = 16;
  localparam logic [7:0] SEED       = 8'hC3;
  localparam logic [7:0] STEP       = 8'h35;
  localparam int         LEN_BITS   = IMG_BYTES * 8;

  logic       clk = 1'b0;
  logic       clk_en = 1'b1;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_code;
  logic       dat_out;
  logic       busy;

  int checks = 0;
  int failures = 0;

  boot_stream_top #(.IMG_BYTES(IMG_BYTES), .SEED(SEED), .STEP(STEP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .dat_out   (dat_out),
    .busy      (busy)
  );

  always begin
    #(CLK_PERIOD / 2);
    if (clk_en) clk = ~clk;
  end

  function automatic logic exp_bit(input int k);
    logic [7:0] b;
    b = SEED + 8'((k / 8) * STEP);
    return b[7 - (k % 8)];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Advance to one time unit after the next falling edge, dropping the strobe.
  task automatic step();
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic issue(input logic [1:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy in reset", busy, 1'b0);
    check("R1 dat in reset", dat_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 busy after reset", busy, 1'b0);
    check("R1 dat after reset", dat_out, 1'b1);
  endtask

  task automatic t_ignore_idle();
    for (int c = 0; c < 3; c++) begin
      step();
      issue(2'(c));
      step();
      check("R2 busy unchanged", busy, 1'b0);
      check("R10 dat high idle", dat_out, 1'b1);
    end
  endtask

  task automatic t_full_stream();
    step();
    issue(2'b11);
    step();
    check("R3 busy set", busy, 1'b1);
    check("R3 R4 R5 bit 0", dat_out, exp_bit(0));
    for (int k = 1; k < LEN_BITS; k++) begin
      step();
      check("R4 R5 image bit", dat_out, exp_bit(k));
    end
    for (int j = 0; j < 5; j++) begin
      step();
      check("R8 dat high after end", dat_out, 1'b1);
      check("R8 busy held after end", busy, 1'b1);
    end
    issue(2'b01);
    step();
    check("R7 go-idle closes", busy, 1'b0);
    check("R10 dat high after close", dat_out, 1'b1);
  endtask

  task automatic t_no_restart();
    step();
    issue(2'b11);
    for (int k = 0; k < 31; k++) begin
      step();
      check("R6 stream bit", dat_out, exp_bit(k));
      if (k == 9)  issue(2'b11);
      if (k == 19) issue(2'b00);
    end
    issue(2'b10);
    step();
    check("R7 pre-idle aborts busy", busy, 1'b0);
    check("R7 pre-idle aborts dat", dat_out, 1'b1);
    step();
    check("R10 dat stays high", dat_out, 1'b1);
  endtask

  task automatic t_abort_on_zero();
    bit hit = 0;
    step();
    issue(2'b11);
    for (int k = 0; k < LEN_BITS && !hit; k++) begin
      step();
      check("R4 stream bit", dat_out, exp_bit(k));
      if (k >= 4 && exp_bit(k) == 1'b0) begin
        check("R7 low before abort", dat_out, 1'b0);
        issue(2'b01);
        hit = 1;
      end
    end
    step();
    check("R7 go-idle aborts busy", busy, 1'b0);
    check("R7 dat high after abort", dat_out, 1'b1);
  endtask

  task automatic t_clock_pause();
    step();
    issue(2'b11);
    for (int k = 0; k < 24; k++) begin
      step();
      check("R9 stream bit", dat_out, exp_bit(k));
      if (k == 11 || k == 17) begin
        clk_en = 1'b0;
        #(4 * CLK_PERIOD);
        check("R9 dat held while paused", dat_out, exp_bit(k));
        check("R9 busy held while paused", busy, 1'b1);
        clk_en = 1'b1;
      end
    end
    issue(2'b01);
    step();
    check("R7 close after pause", busy, 1'b0);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    t_ignore_idle();
    t_full_stream();
    t_no_restart();
    t_abort_on_zero();
    t_clock_pause();
    do_reset();
    finish_run();
  end
endmodule